// File: doc/BRIEF.md
# Reverse-Search Emulated EEPROM Reader

This block answers read requests against a byte-addressed nonvolatile store that is emulated on top of a flash-like word array. Writers elsewhere append 24-bit records to one page per bank. Each record pairs a small address tag with a 16-bit value, so later records for a tag supersede earlier ones. The reader turns a logical address into its owning bank and the tag within that bank. It probes the bank's pages in ascending order until it finds the one whose status word marks it current. It then walks that page from its top record down toward the status word, and the first record whose tag matches supplies the value.

A logical address that was never stored reads back as all ones, which is what an erased EEPROM cell would return. An address beyond the configured size also reads as all ones, and so does a bank with no current page. Each of these three outcomes raises a sticky error flag, and only an explicit clear input resets the flags. The flash is reached through a plain synchronous word-read port with one cycle of latency. Programming, erasing and compaction belong to other blocks.

Top module: `eer_reader`

## Requirements
- R1: A flash word is a record with the tag in bits 23:16 and the value in bits 15:0. On a hit, `rd_data` carries bits 15:0 of the matching record.
- R2: Word 0 of every page is the status word. The scan never reads it as a record. A miss ends after word 1 has been checked.
- R3: The bank index is the logical address divided by `BANK_SIZE`, and the tag is the remainder. The flash word address is {bank, page, word}, with the page and word fields each `PG_W` and `WD_W` bits wide.
- R4: A logical address at or above `NUM_BANKS*BANK_SIZE` gives `rd_data` = 0xFFFF and sets `err_illegal`. It issues no flash read, and `rd_done` is high in the cycle right after the start edge.
- R5: The page probe checks word 0 of page 0, page 1, and so on in turn, and uses the first current page it finds. If no page in the bank is current, the block returns 0xFFFF and sets `err_corrupt` after `PAGES` probes.
- R6: The scan starts at the highest word of the page and steps downward. The first tag match ends the scan, so the newest record wins.
- R7: If the scan reaches word 1 without a match, the block returns 0xFFFF and sets `err_miss`.
- R8: Status bit 19 is active low: 0 means the page is current, and 1 means it is not.
- R9: Erased slots (tag 0xFF) are passed over without ending the scan.
- R10: Each flash read takes one request cycle and one check cycle. Reads are never issued back to back. `rd_done` pulses for one cycle, and `rd_data` and the flags are valid in that cycle.
- R11: The error flags stay set until `flag_clr` is high at a clock edge. If an error event and `flag_clr` arrive in the same cycle, the flag is set.
- R12: A start strobe that arrives while a lookup is in progress is ignored.
- R13: After reset, `rd_done` is 0, `rd_data` is 0xFFFF, all flags are 0 and no flash read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_start | input | 1 | Start a lookup (sampled while idle) |
| rd_laddr | input | LA_W | Logical address to look up |
| flag_clr | input | 1 | Clear all sticky error flags |
| fl_re | output | 1 | Flash word read request |
| fl_addr | output | FA_W | Flash word address {bank, page, word} |
| fl_rdata | input | 24 | Flash word, valid the cycle after `fl_re` |
| rd_data | output | 16 | Lookup result |
| rd_done | output | 1 | One-cycle pulse: result and flags valid |
| err_illegal | output | 1 | Sticky: address out of range |
| err_corrupt | output | 1 | Sticky: no current page in the bank |
| err_miss | output | 1 | Sticky: address never written |

## Verification
Assertions check several properties on every cycle. Flash reads are spaced apart, and the scan never requests a status word as a record. Each error flag rises only together with a done pulse that carries all ones. Flags hold until cleared, and at most one error event occurs per cycle. The bench scenarios are what show the lookup semantics. These include newest-record-wins ordering, the skipping of non-current pages that hold stale records, and the bank split across the address range. They also cover the exact completion latency for each outcome, the ignoring of a mid-lookup start, and a clear that collides with a new error.

// File: rtl/eer_pkg.sv
// Shared types for the emulated-EEPROM reader.
// Assumes: records are 24 bits, with the tag in the top byte and the value in the low 16 bits.
package eer_pkg;
    localparam int REC_W   = 24;
    localparam int VAL_W   = 16;
    localparam int TAG_W   = 8;
    localparam int CUR_BIT = 19;   // page-current flag, active low

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREQ,   // request status word of a candidate page
        ST_FCHK,   // inspect status word
        ST_SREQ,   // request a record during the reverse scan
        ST_SCHK    // compare the record tag
    } eer_state_t;
endpackage

// File: rtl/eer_bank_decode.sv
// Splits a logical address into bank index and in-bank tag, and flags range.
// Assumes: BANK_SIZE <= 255, so every legal tag differs from the erased tag 0xFF.
module eer_bank_decode #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_SIZE = 10,
    parameter int LA_W      = 8,
    parameter int BANK_W    = 1
) (
    input  logic [LA_W-1:0]   laddr_i,
    output logic              legal_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [7:0]        tag_o
);
    localparam int TOTAL = NUM_BANKS * BANK_SIZE;

    logic [NUM_BANKS-1:0] at_or_above;
    logic [LA_W-1:0]      base;

    // One comparator per bank boundary.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bound
        if (b == 0) begin : g_first
            assign at_or_above[b] = 1'b1;
        end else begin : g_rest
            assign at_or_above[b] = (laddr_i >= LA_W'(b * BANK_SIZE));
        end
    end

    // Range check against the total emulated size.
    assign legal_o = (laddr_i < LA_W'(TOTAL));

    // Highest boundary passed selects the bank; the remainder is the tag.
    always_comb begin
        bank_o = '0;
        base   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (at_or_above[b]) begin
                bank_o = BANK_W'(b);
                base   = LA_W'(b * BANK_SIZE);
            end
        end
        tag_o = 8'(laddr_i - base);
        if (legal_o) begin
            assert_tag_in_bank_R3: assert (tag_o < 8'(BANK_SIZE));
        end
    end
endmodule

// File: rtl/eer_rec_match.sv
// Interprets a flash word both as a page status word and as a data record.
// Assumes: the caller knows which interpretation applies in the current state.
module eer_rec_match
    import eer_pkg::*;
(
    input  logic [REC_W-1:0] word_i,
    input  logic [TAG_W-1:0] key_i,
    output logic             page_cur_o,
    output logic             hit_o,
    output logic [VAL_W-1:0] val_o
);
    // Status view: bit 19 low marks the current page.
    assign page_cur_o = ~word_i[CUR_BIT];
    // Record view: tag compare and value extract.
    assign hit_o      = (word_i[REC_W-1:VAL_W] == key_i);
    assign val_o      = word_i[VAL_W-1:0];
endmodule

// File: rtl/eer_scan_fsm.sv
// Sequencer: probes page status words in ascending order, then scans the
// current page from its top word down to word 1.
// Assumes: PAGES and WORDS are powers of two, and the flash read has one cycle of latency.
module eer_scan_fsm
    import eer_pkg::*;
#(
    parameter int PAGES  = 4,
    parameter int WORDS  = 16,
    parameter int BANK_W = 1,
    parameter int PG_W   = 2,
    parameter int WD_W   = 4,
    parameter int FA_W   = BANK_W + PG_W + WD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              legal_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [7:0]        tag_i,
    input  logic              page_cur_i,
    input  logic              hit_i,
    input  logic [VAL_W-1:0]  val_i,
    output logic [TAG_W-1:0]  key_o,
    output logic              fl_re_o,
    output logic [FA_W-1:0]   fl_addr_o,
    output logic              ev_illegal_o,
    output logic              ev_corrupt_o,
    output logic              ev_miss_o,
    output logic [VAL_W-1:0]  data_o,
    output logic              done_o
);
    eer_state_t        state_q, state_n;
    logic [BANK_W-1:0] bank_q, bank_n;
    logic [TAG_W-1:0]  key_q, key_n;
    logic [PG_W-1:0]   pg_q, pg_n;
    logic [WD_W-1:0]   wd_q, wd_n;
    logic              fin, fin_hit;

    assign key_o = key_q;

    // Next-state, flash request and completion decode.
    always_comb begin
        state_n      = state_q;
        bank_n       = bank_q;
        key_n        = key_q;
        pg_n         = pg_q;
        wd_n         = wd_q;
        fl_re_o      = 1'b0;
        fl_addr_o    = {bank_q, pg_q, wd_q};
        fin          = 1'b0;
        fin_hit      = 1'b0;
        ev_illegal_o = 1'b0;
        ev_corrupt_o = 1'b0;
        ev_miss_o    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!legal_i) begin
                        fin          = 1'b1;
                        ev_illegal_o = 1'b1;
                    end else begin
                        bank_n  = bank_i;
                        key_n   = tag_i;
                        pg_n    = '0;
                        state_n = ST_FREQ;
                    end
                end
            end
            ST_FREQ: begin
                fl_re_o   = 1'b1;
                fl_addr_o = {bank_q, pg_q, {WD_W{1'b0}}};
                state_n   = ST_FCHK;
            end
            ST_FCHK: begin
                if (page_cur_i) begin
                    wd_n    = WD_W'(WORDS - 1);
                    state_n = ST_SREQ;
                end else if (pg_q == PG_W'(PAGES - 1)) begin
                    fin          = 1'b1;
                    ev_corrupt_o = 1'b1;
                    state_n      = ST_IDLE;
                end else begin
                    pg_n    = pg_q + 1'b1;
                    state_n = ST_FREQ;
                end
            end
            ST_SREQ: begin
                fl_re_o = 1'b1;
                state_n = ST_SCHK;
            end
            ST_SCHK: begin
                if (hit_i) begin
                    fin     = 1'b1;
                    fin_hit = 1'b1;
                    state_n = ST_IDLE;
                end else if (wd_q == WD_W'(1)) begin
                    fin       = 1'b1;
                    ev_miss_o = 1'b1;
                    state_n   = ST_IDLE;
                end else begin
                    wd_n    = wd_q - 1'b1;
                    state_n = ST_SREQ;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Control registers of the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            key_q   <= '0;
            pg_q    <= '0;
            wd_q    <= '0;
        end else begin
            state_q <= state_n;
            bank_q  <= bank_n;
            key_q   <= key_n;
            pg_q    <= pg_n;
            wd_q    <= wd_n;
        end
    end

    // Result register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '1;
            done_o <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                data_o <= fin_hit ? val_i : '1;
            end
        end
    end

    // The record scan never requests the status word.
    assert_scan_skips_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SREQ) |-> (wd_q != '0));
endmodule

// File: rtl/eer_flag_bank.sv
// Sticky error flags with a shared clear; a new event wins over the clear.
// Assumes: at most one event per cycle.
module eer_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ev_illegal_i,
    input  logic ev_corrupt_i,
    input  logic ev_miss_i,
    output logic illegal_o,
    output logic corrupt_o,
    output logic miss_o
);
    // Set-dominant sticky update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_o <= 1'b0;
            corrupt_o <= 1'b0;
            miss_o    <= 1'b0;
        end else begin
            illegal_o <= ev_illegal_i | (illegal_o & ~clr_i);
            corrupt_o <= ev_corrupt_i | (corrupt_o & ~clr_i);
            miss_o    <= ev_miss_i    | (miss_o    & ~clr_i);
        end
    end

    assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_illegal_i, ev_corrupt_i, ev_miss_i}));
    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_o && !clr_i) |=> miss_o);
endmodule

// File: rtl/eer_reader.sv
// Top: reverse-search reader for an emulated EEPROM kept as an append-only
// record log inside one current page per bank of a flash-like array.
// Assumes: synchronous flash read port with one cycle of latency, and power-of-two page geometry.
module eer_reader
    import eer_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_SIZE = 10,
    parameter int PAGES     = 4,
    parameter int WORDS     = 16,
    parameter int LA_W      = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PG_W     = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int WD_W     = $clog2(WORDS),
    localparam int FA_W     = BANK_W + PG_W + WD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [LA_W-1:0]   rd_laddr,
    input  logic              flag_clr,
    output logic              fl_re,
    output logic [FA_W-1:0]   fl_addr,
    input  logic [REC_W-1:0]  fl_rdata,
    output logic [VAL_W-1:0]  rd_data,
    output logic              rd_done,
    output logic              err_illegal,
    output logic              err_corrupt,
    output logic              err_miss
);
    logic              legal;
    logic [BANK_W-1:0] bank;
    logic [7:0]        tag;
    logic [TAG_W-1:0]  key;
    logic              page_cur, hit;
    logic [VAL_W-1:0]  val;
    logic              ev_ill, ev_cor, ev_miss;

    eer_bank_decode #(
        .NUM_BANKS(NUM_BANKS), .BANK_SIZE(BANK_SIZE), .LA_W(LA_W), .BANK_W(BANK_W)
    ) u_dec (
        .laddr_i(rd_laddr), .legal_o(legal), .bank_o(bank), .tag_o(tag)
    );

    eer_rec_match u_match (
        .word_i(fl_rdata), .key_i(key), .page_cur_o(page_cur), .hit_o(hit), .val_o(val)
    );

    eer_scan_fsm #(
        .PAGES(PAGES), .WORDS(WORDS), .BANK_W(BANK_W), .PG_W(PG_W), .WD_W(WD_W), .FA_W(FA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(rd_start), .legal_i(legal), .bank_i(bank),
        .tag_i(tag), .page_cur_i(page_cur), .hit_i(hit), .val_i(val), .key_o(key),
        .fl_re_o(fl_re), .fl_addr_o(fl_addr), .ev_illegal_o(ev_ill), .ev_corrupt_o(ev_cor),
        .ev_miss_o(ev_miss), .data_o(rd_data), .done_o(rd_done)
    );

    eer_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .clr_i(flag_clr), .ev_illegal_i(ev_ill),
        .ev_corrupt_i(ev_cor), .ev_miss_i(ev_miss), .illegal_o(err_illegal),
        .corrupt_o(err_corrupt), .miss_o(err_miss)
    );

    // Each read request is followed by a check cycle.
    assert_read_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |=> !fl_re);
    assert_illegal_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_illegal) |-> (rd_done && rd_data == '1));
    assert_corrupt_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_corrupt) |-> (rd_done && rd_data == '1));
    assert_miss_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_miss) |-> (rd_done && rd_data == '1));
endmodule

// File: tb/tb_eer_reader.sv
// Bench: behavioural flash model plus a lookup reference computing value,
// outcome and exact completion latency; done is compared on every clock.
module tb_eer_reader;
    localparam int NB = 2, BS = 10, NP = 4, NW = 16, LA_W = 8;
    localparam int FA_W = 1 + 2 + 4;
    localparam int MW = NB * NP * NW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_start = 1'b0, flag_clr = 1'b0;
    logic [LA_W-1:0] rd_laddr = '0;
    logic fl_re;
    logic [FA_W-1:0] fl_addr;
    logic [23:0] fl_rdata = '0;
    logic [15:0] rd_data;
    logic rd_done, err_illegal, err_corrupt, err_miss;

    logic [23:0] mem [MW];
    int total = 0, bad = 0, rd_cnt = 0;
    bit ended = 0;
    bit x_ill = 0, x_cor = 0, x_miss = 0;

    always #2 clk = ~clk;

    eer_reader dut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_laddr(rd_laddr),
        .flag_clr(flag_clr), .fl_re(fl_re), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
        .rd_data(rd_data), .rd_done(rd_done), .err_illegal(err_illegal),
        .err_corrupt(err_corrupt), .err_miss(err_miss)
    );

    // Flash model with one-cycle read latency.
    always @(posedge clk) begin
        if (fl_re) begin
            fl_rdata <= mem[fl_addr];
            rd_cnt   <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int widx(int b, int p, int w);
        return (b * NP + p) * NW + w;
    endfunction

    // Reference: code 0 hit, 1 illegal, 2 corrupt, 3 miss.
    task automatic model(input int a, output int d, output int code, output int lat);
        int b, t, p;
        d = 16'hFFFF;
        if (a >= NB * BS) begin code = 1; lat = 0; return; end
        b = a / BS; t = a % BS; p = -1;
        for (int i = 0; i < NP; i++)
            if (p < 0 && mem[widx(b, i, 0)][19] == 1'b0) p = i;
        if (p < 0) begin code = 2; lat = 2 * NP; return; end
        for (int j = 1; j < NW; j++) begin
            if (mem[widx(b, p, NW - j)][23:16] == t[7:0]) begin
                d = mem[widx(b, p, NW - j)][15:0]; code = 0; lat = 2 * (p + 1) + 2 * j; return;
            end
        end
        code = 3; lat = 2 * (p + 1) + 2 * (NW - 1);
    endtask

    // One lookup; optionally strobe a second start with another address at cycle inj.
    task automatic lookup(input string req, input int a, input int inj = -1, input int other = 0);
        int d, code, lat;
        model(a, d, code, lat);
        @(negedge clk);
        rd_laddr = LA_W'(a); rd_start = 1'b1; rd_cnt = 0;
        for (int c = 0; c <= lat; c++) begin
            @(negedge clk);
            rd_start = 1'b0;
            if (c == inj) begin rd_start = 1'b1; rd_laddr = LA_W'(other); end
            chk({req, " R10 done timing"}, int'(rd_done), int'(c == lat));
        end
        if (!flag_clr) begin
            if (code == 1) x_ill = 1;
            if (code == 2) x_cor = 1;
            if (code == 3) x_miss = 1;
        end else begin
            x_ill = (code == 1); x_cor = (code == 2); x_miss = (code == 3);
        end
        chk({req, " data"}, int'(rd_data), d);
        chk({req, " R10 read count"}, rd_cnt, lat / 2);
        chk({req, " flag illegal"}, int'(err_illegal), int'(x_ill));
        chk({req, " flag corrupt"}, int'(err_corrupt), int'(x_cor));
        chk({req, " flag miss"}, int'(err_miss), int'(x_miss));
        rd_start = 1'b0;
        @(negedge clk);
        chk({req, " R10 done one cycle"}, int'(rd_done), 0);
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        x_ill = 0; x_cor = 0; x_miss = 0;
        chk("R11 clear", int'({err_illegal, err_corrupt, err_miss}), 0);
    endtask

    initial begin
        for (int i = 0; i < MW; i++) mem[i] = 24'hFFFFFF;
        // Bank 0: page 0 not current but holds a stale record; page 2 current.
        mem[widx(0, 0, 1)] = {8'd3, 16'hDEAD};
        mem[widx(0, 2, 0)] = 24'hF7FFFF;
        mem[widx(0, 2, 1)] = {8'd2, 16'h0202};
        mem[widx(0, 2, 2)] = {8'd7, 16'h0707};
        mem[widx(0, 2, 3)] = {8'd2, 16'h2222};
        mem[widx(0, 2, 4)] = {8'd9, 16'h0909};
        mem[widx(0, 2, 5)] = {8'd7, 16'h7777};
        // Bank 1: page 0 current, with records at the bottom, near the top and at the top.
        mem[widx(1, 0, 0)]  = 24'hF7FFFF;
        mem[widx(1, 0, 1)]  = {8'd0, 16'h1000};
        mem[widx(1, 0, 14)] = {8'd0, 16'h1111};
        mem[widx(1, 0, 15)] = {8'd5, 16'h5555};

        repeat (3) @(negedge clk);
        chk("R13 reset done", int'(rd_done), 0);
        chk("R13 reset data", int'(rd_data), 16'hFFFF);
        chk("R13 reset flags", int'({err_illegal, err_corrupt, err_miss}), 0);
        chk("R13 reset read", int'(fl_re), 0);
        rst_n = 1'b1;

        lookup("R1 R6 R8 newest of tag 2", 2);
        lookup("R6 R9 newest of tag 7", 7);
        lookup("R1 tag 9", 9);
        lookup("R5 R8 stale page ignored, R7", 3);
        lookup("R2 R7 miss walks to word 1", 0);
        lookup("R3 bank 1 tag 0", 10);
        lookup("R3 R6 top slot", 15);
        lookup("R7 bank 1 miss", 19);
        lookup("R4 first illegal", 20);
        lookup("R4 far illegal", 255);
        clear_flags();
        lookup("R12 start ignored while busy", 2, 3, 20);
        lookup("R12 back-to-back after ignore", 7);
        mem[widx(1, 0, 0)] = 24'hFFFFFF;
        lookup("R5 no current page", 12);
        lookup("R11 sticky corrupt after hit", 9);
        clear_flags();
        lookup("R7 miss before collision", 1);
        @(negedge clk); flag_clr = 1'b1;
        lookup("R11 set wins over clear", 30);
        flag_clr = 1'b0;

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule